// File: doc/BRIEF.md
# Trigger Frame Builder

The block gathers trigger words from six front-end sources and turns each beam crossing into one frame of 16-bit words for a serial optical link. A crossing strobe latches every source's two words and its valid flag in a single cycle. The frame is then played out one word per clock. It begins with a marker word that has the same value as the link fill word. Next come a running crossing number and a status word that flags the sources with no data. Twelve payload slots follow. After the frame the block sends the fill word until the next strobe, so the link never loses alignment.

The word clock is assumed fast enough that fifteen words fit inside one crossing period. A strobe that arrives before a frame is complete cuts that frame short and starts the next one at once. The output is an isochronous stream: it carries a word every cycle and offers no back-pressure, because the serializer downstream cannot stall. The input side is sampled only on the strobe, so the sources need no handshake. Fill words are distinguished from frame words by the frame flag and by the start-of-frame marker.

Top module: `trig_frame_builder`

## Requirements
- R1: While reset is held and after it is released, the output is the fill word 16'hBC3C with `out_sof` and `out_frame` low.
- R2: Before the first crossing strobe after reset, every cycle carries the fill word with `out_sof` and `out_frame` low.
- R3: The cycle after a strobe is sampled, the output is the marker word (equal to the fill word 16'hBC3C), with `out_sof` and `out_frame` both high.
- R4: The second word of a frame is the crossing number. It is 0 in the first frame after reset and rises by one with each later strobe.
- R5: The crossing number is 16 bits wide and goes from 65535 back to 0.
- R6: The third word is the status word. Bit i (i = 0..5) is 1 when source i had `src_valid[i]` low at the strobe, and bits 15:6 are 0.
- R7: Words 4 to 15 are payload slots in order of source 0..5, then word 0..1 within a source. Source i word j comes from `src_words[(2*i+j)*16 +: 16]`. A source that was not valid at the strobe yields zeros in both of its slots.
- R8: Sources are captured only at the strobe. Changes to `src_valid` or `src_words` during a frame do not alter that frame.
- R9: After the fifteenth word of a frame, the output returns to the fill word with `out_frame` and `out_sof` low until the next strobe.
- R10: A strobe during a frame ends that frame after the words already sent. The next cycle starts a complete new frame carrying the newly captured data and the next crossing number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xing_strobe | input | 1 | One-cycle beam-crossing strobe; captures sources and starts a frame |
| src_valid | input | 6 | Per-source flag: data for this crossing is present |
| src_words | input | 192 | Two 16-bit words per source, source-major packing |
| out_word | output | 16 | Link word stream |
| out_sof | output | 1 | High on the first word of a frame |
| out_frame | output | 1 | High on all fifteen frame words |

## Verification
Full frames are sent with every source valid, with alternating sources missing, and with all sources missing. Together these separate correct slot order from swapped sources or swapped words, and correct zero fill from stale data. In one frame the inputs are scrambled while it is on the wire, which exposes any path that bypasses the capture registers. Back-to-back strobes spaced a few words apart show whether a truncated frame restarts cleanly. A long strobe burst drives the crossing number to 65535 and then to 0, so its width and wrap are checked at the output.

// File: rtl/tfb_pkg.sv
package tfb_pkg;

  // Kind of word presented on the link in the current cycle.
  typedef enum logic [2:0] {
    WK_FILL,
    WK_MARK,
    WK_COUNT,
    WK_STATUS,
    WK_SLOT
  } word_kind_e;

  // Marker, crossing number and status precede the payload slots.
  localparam int unsigned HDR_WORDS = 3;

endpackage

// File: rtl/tfb_xing_counter.sv
module tfb_xing_counter #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  output logic [WORD_W-1:0] frame_num
);

  logic [WORD_W-1:0] next_num;

  // frame_num keeps the number of the frame being sent; next_num runs ahead.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_num  <= '0;
      frame_num <= '0;
    end else if (capture) begin
      frame_num <= next_num;
      next_num  <= next_num + 1'b1;
    end
  end

endmodule

// File: rtl/tfb_src_latch.sv
module tfb_src_latch #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned WPS    = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  capture,
  input  logic                  in_valid,
  input  logic [WPS*WORD_W-1:0] in_words,
  output logic [WPS*WORD_W-1:0] held_words,
  output logic                  missing
);

  // Absent sources are zeroed at capture so the mux never sees stale data.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_words <= '0;
      missing    <= 1'b0;
    end else if (capture) begin
      held_words <= in_valid ? in_words : '0;
      missing    <= ~in_valid;
    end
  end

endmodule

// File: rtl/tfb_frame_seq.sv
module tfb_frame_seq #(
  parameter int unsigned FRAME_LEN = 15,
  parameter int unsigned IDXW      = $clog2(FRAME_LEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic [IDXW-1:0] word_idx,
  output logic            active
);

  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(FRAME_LEN - 1);

  // A start always wins, so a late strobe restarts the frame at word 0.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_idx <= '0;
      active   <= 1'b0;
    end else if (start) begin
      word_idx <= '0;
      active   <= 1'b1;
    end else if (active) begin
      if (word_idx == LAST_IDX) begin
        word_idx <= '0;
        active   <= 1'b0;
      end else begin
        word_idx <= word_idx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/tfb_word_mux.sv
module tfb_word_mux
  import tfb_pkg::*;
#(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned NSRC      = 6,
  parameter int unsigned NSLOT     = 12,
  parameter int unsigned IDXW      = 4,
  parameter logic [WORD_W-1:0] IDLE_WORD = 16'hBC3C
) (
  input  logic                    active,
  input  logic [IDXW-1:0]         word_idx,
  input  logic [WORD_W-1:0]       frame_num,
  input  logic [NSRC-1:0]         missing,
  input  logic [NSLOT*WORD_W-1:0] slot_flat,
  output logic [WORD_W-1:0]       out_word,
  output logic                    out_sof,
  output logic                    out_frame
);

  logic [WORD_W-1:0] slot_arr [NSLOT];
  logic [IDXW-1:0]   slot_sel;
  logic [WORD_W-1:0] status_word;
  word_kind_e        kind;

  for (genvar gs = 0; gs < NSLOT; gs++) begin : g_slot
    assign slot_arr[gs] = slot_flat[gs*WORD_W +: WORD_W];
  end

  assign slot_sel    = word_idx - IDXW'(HDR_WORDS);
  assign status_word = {{(WORD_W-NSRC){1'b0}}, missing};

  always_comb begin
    kind = WK_FILL;
    if (active) begin
      if (word_idx == IDXW'(0))      kind = WK_MARK;
      else if (word_idx == IDXW'(1)) kind = WK_COUNT;
      else if (word_idx == IDXW'(2)) kind = WK_STATUS;
      else                           kind = WK_SLOT;
    end
  end

  always_comb begin
    unique case (kind)
      WK_MARK:   out_word = IDLE_WORD;
      WK_COUNT:  out_word = frame_num;
      WK_STATUS: out_word = status_word;
      WK_SLOT:   out_word = (slot_sel < IDXW'(NSLOT)) ? slot_arr[slot_sel] : '0;
      default:   out_word = IDLE_WORD;
    endcase
  end

  assign out_sof   = (kind == WK_MARK);
  assign out_frame = (kind != WK_FILL);

endmodule

// File: rtl/trig_frame_builder.sv
module trig_frame_builder
  import tfb_pkg::*;
#(
  parameter int unsigned NSRC   = 6,
  parameter int unsigned WPS    = 2,
  parameter int unsigned WORD_W = 16,
  parameter logic [WORD_W-1:0] IDLE_WORD = 16'hBC3C
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       xing_strobe,
  input  logic [NSRC-1:0]            src_valid,
  input  logic [NSRC*WPS*WORD_W-1:0] src_words,
  output logic [WORD_W-1:0]          out_word,
  output logic                       out_sof,
  output logic                       out_frame
);

  localparam int unsigned NSLOT     = NSRC * WPS;
  localparam int unsigned FRAME_LEN = NSLOT + HDR_WORDS;
  localparam int unsigned IDXW      = $clog2(FRAME_LEN);
  localparam int unsigned SRC_W     = WPS * WORD_W;

  logic [NSRC-1:0]         missing;
  logic [NSLOT*WORD_W-1:0] slot_flat;
  logic [WORD_W-1:0]       frame_num;
  logic [IDXW-1:0]         word_idx;
  logic                    active;

  for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
    tfb_src_latch #(
      .WORD_W (WORD_W),
      .WPS    (WPS)
    ) u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .capture    (xing_strobe),
      .in_valid   (src_valid[gi]),
      .in_words   (src_words[gi*SRC_W +: SRC_W]),
      .held_words (slot_flat[gi*SRC_W +: SRC_W]),
      .missing    (missing[gi])
    );
  end

  tfb_xing_counter #(
    .WORD_W (WORD_W)
  ) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (xing_strobe),
    .frame_num (frame_num)
  );

  tfb_frame_seq #(
    .FRAME_LEN (FRAME_LEN),
    .IDXW      (IDXW)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (xing_strobe),
    .word_idx (word_idx),
    .active   (active)
  );

  tfb_word_mux #(
    .WORD_W    (WORD_W),
    .NSRC      (NSRC),
    .NSLOT     (NSLOT),
    .IDXW      (IDXW),
    .IDLE_WORD (IDLE_WORD)
  ) u_mux (
    .active    (active),
    .word_idx  (word_idx),
    .frame_num (frame_num),
    .missing   (missing),
    .slot_flat (slot_flat),
    .out_word  (out_word),
    .out_sof   (out_sof),
    .out_frame (out_frame)
  );

endmodule

// File: rtl/tfb_checker.sv
module tfb_checker #(
  parameter int unsigned NSRC      = 6,
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned FRAME_LEN = 15,
  parameter logic [WORD_W-1:0] IDLE_WORD = 16'hBC3C
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xing_strobe,
  input logic [NSRC-1:0]   src_valid,
  input logic [WORD_W-1:0] out_word,
  input logic              out_sof,
  input logic              out_frame
);

  localparam int unsigned AGEW = $clog2(FRAME_LEN) + 1;
  localparam logic [AGEW-1:0] AGE_MAX = AGEW'(FRAME_LEN);

  logic [WORD_W-1:0] seen;
  logic [AGEW-1:0]   age;
  logic              any_strobe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen       <= '0;
      age        <= AGE_MAX;
      any_strobe <= 1'b0;
    end else if (xing_strobe) begin
      seen       <= seen + 1'b1;
      age        <= '0;
      any_strobe <= 1'b1;
    end else if (age != AGE_MAX) begin
      age        <= age + 1'b1;
    end
  end

  // R3
  sof_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xing_strobe |=> (out_sof && out_frame && out_word == IDLE_WORD));

  // R2
  fill_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_frame |-> (out_word == IDLE_WORD && !out_sof));

  // R4
  crossing_num_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sof && !xing_strobe) |=> (WORD_W'(out_word + 1'b1) == $past(seen)));

  // R6
  status_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sof && !xing_strobe) ##1 !xing_strobe |=>
      (out_word == {{(WORD_W-NSRC){1'b0}}, ~$past(src_valid, 3)}));

  // R9
  frame_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == AGE_MAX) |-> !out_frame);

  // R10
  frame_spans_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_strobe && age < AGE_MAX) |-> out_frame);

endmodule

bind trig_frame_builder tfb_checker #(
  .NSRC      (NSRC),
  .WORD_W    (WORD_W),
  .FRAME_LEN (FRAME_LEN),
  .IDLE_WORD (IDLE_WORD)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .xing_strobe (xing_strobe),
  .src_valid   (src_valid),
  .out_word    (out_word),
  .out_sof     (out_sof),
  .out_frame   (out_frame)
);

// File: tb/trig_frame_builder_bench.sv
module trig_frame_builder_bench;

  localparam int NSRC = 6;
  localparam int WPS  = 2;
  localparam int W    = 16;
  localparam int NSL  = NSRC * WPS;
  localparam int FLEN = NSL + 3;
  localparam logic [W-1:0] IDLE = 16'hBC3C;

  typedef struct packed {
    logic [FLEN-1:0][W-1:0] w;
    logic [7:0]             len;
    logic [1:0]             tag;   // 0 plain, 1 wrap, 2 scrambled inputs, 3 restart
  } frame_t;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    xing_strobe = 1'b0;
  logic [NSRC-1:0]         src_valid = '0;
  logic [NSRC*WPS*W-1:0]   src_words = '0;
  logic [W-1:0]            out_word;
  logic                    out_sof;
  logic                    out_frame;

  int     tests = 0;
  int     fails = 0;
  bit     mon_en = 1'b0;
  bit     done = 1'b0;
  logic [W-1:0] exp_cnt = '0;
  logic [7:0]   prev_len = 8'(FLEN);
  frame_t exp_q[$];

  always #5 clk = ~clk;

  trig_frame_builder u_trig_frame_builder (
    .clk         (clk),
    .rst_n       (rst_n),
    .xing_strobe (xing_strobe),
    .src_valid   (src_valid),
    .src_words   (src_words),
    .out_word    (out_word),
    .out_sof     (out_sof),
    .out_frame   (out_frame)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string word_tag(input int k, input logic [1:0] tag);
    if (tag == 2'd3) return "R10";
    if (k == 0) return "R3";
    if (k == 1) return (tag == 2'd1) ? "R5" : "R4";
    if (k == 2) return "R6";
    return (tag == 2'd2) ? "R8" : "R7";
  endfunction

  // Driver: predicts the frame, then pulses the strobe for one edge.
  task automatic send_xing(input logic [NSRC-1:0] v, input logic [NSRC*WPS*W-1:0] d,
                           input int len, input logic [1:0] tag);
    frame_t f;
    f.w[0] = IDLE;
    f.w[1] = exp_cnt;
    f.w[2] = {{(W-NSRC){1'b0}}, ~v};
    for (int k = 0; k < NSL; k++)
      f.w[3+k] = v[k/WPS] ? d[k*W +: W] : '0;
    f.len = 8'(len);
    f.tag = (prev_len != 8'(FLEN)) ? 2'd3 : tag;
    prev_len = 8'(len);
    exp_q.push_back(f);
    exp_cnt = exp_cnt + 1'b1;
    xing_strobe = 1'b1;
    src_valid   = v;
    src_words   = d;
    @(negedge clk);
    xing_strobe = 1'b0;
  endtask

  task automatic gap(input int n, input bit scramble);
    for (int i = 0; i < n; i++) begin
      if (scramble) begin
        src_valid = NSRC'($urandom);
        for (int j = 0; j < NSRC*WPS; j++) src_words[j*W +: W] = W'($urandom);
      end
      @(negedge clk);
    end
  endtask

  function automatic logic [NSRC*WPS*W-1:0] pattern(input logic [7:0] seed);
    logic [NSRC*WPS*W-1:0] d;
    for (int k = 0; k < NSRC*WPS; k++) d[k*W +: W] = {seed, 4'(k / WPS), 4'(k % WPS)};
    return d;
  endfunction

  // Monitor: pops one prediction per start-of-frame and compares word by word.
  initial begin
    frame_t cur;
    forever begin
      @(negedge clk);
      if (mon_en) begin
        if (out_sof) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R3 unexpected frame", out_word, IDLE);
          end else begin
            cur = exp_q.pop_front();
            for (int k = 0; k < int'(cur.len); k++) begin
              if (k > 0) @(negedge clk);
              chk(out_word == cur.w[k] && out_frame && (out_sof == (k == 0)),
                  word_tag(k, cur.tag), out_word, cur.w[k]);
            end
          end
        end else begin
          chk(out_word == IDLE && !out_frame, "R2 R9 fill", out_word, IDLE);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk(out_word == IDLE && !out_sof && !out_frame, "R1 in reset", out_word, IDLE);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_word == IDLE && !out_sof && !out_frame, "R1 after reset", out_word, IDLE);
    mon_en = 1'b1;
    gap(4, 1'b0);

    // All sources valid, distinct words per slot.
    send_xing('1, pattern(8'hA1), FLEN, 2'd0);
    gap(FLEN - 1 + 3, 1'b0);
    // Alternate sources missing.
    send_xing(6'b010101, pattern(8'hB2), FLEN, 2'd0);
    gap(FLEN - 1, 1'b0);
    // No source valid.
    send_xing('0, pattern(8'hC3), FLEN, 2'd0);
    gap(FLEN - 1 + 2, 1'b0);
    // Inputs scrambled while the frame is on the wire.
    send_xing(6'b110011, pattern(8'hD4), FLEN, 2'd2);
    gap(FLEN - 1 + 2, 1'b1);
    // Truncated frame followed by a restart.
    send_xing('1, pattern(8'hE5), 5, 2'd0);
    gap(4, 1'b0);
    send_xing(6'b101010, pattern(8'hF6), FLEN, 2'd0);
    gap(FLEN - 1 + 4, 1'b0);

    // Burst the crossing number up to 65535, then watch the wrap.
    mon_en = 1'b0;
    xing_strobe = 1'b1;
    for (int i = 0; i < 65535 - int'(exp_cnt); i++) @(negedge clk);
    xing_strobe = 1'b0;
    exp_cnt = 16'hFFFF;
    gap(FLEN + 4, 1'b0);
    mon_en = 1'b1;
    send_xing('1, pattern(8'h17), FLEN, 2'd1);
    gap(FLEN - 1 + 2, 1'b0);
    send_xing(6'b000111, pattern(8'h28), FLEN, 2'd1);
    gap(FLEN - 1 + 4, 1'b0);

    chk(exp_q.size() == 0, "R9 all frames seen", W'(exp_q.size()), '0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule